// File: doc/BRIEF.md
# Operand Bypass Selection Unit

This block steers the two source operands of the execute stage in a five-stage integer pipeline. For each operand it compares the source register number held at the start of execute with the destinations of the two older instructions still in flight. Those older instructions sit one stage ahead (the memory-stage register) and two stages ahead (the writeback-stage register). The block then picks one of three values: the register-file read, the memory-stage ALU result, or the writeback value. Each decision is a 2-bit select, and the block also outputs the chosen operand value.

When both older instructions write the same register, the younger one, which sits in the memory stage, supplies the value. For a load sitting in the writeback stage, the forwarded value is the memory read data and not its address result. The register file is assumed to return a value written in the same cycle, so the block has no path from writeback back to decode. Selects and operand values are registered: each result appears one clock after the inputs that produce it.

Top module: `bypass_sel_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, both selects become 2'b00 and both operand outputs become zero, whatever the other inputs are.
- R2: When `exm_wen` is 1, `exm_dst` is nonzero and equals an operand's source number, that operand's select becomes 2'b10 and its value becomes `exm_result`.
- R3: When only the writeback-stage instruction matches (`mwb_wen` is 1, `mwb_dst` is nonzero and equals the source), the select becomes 2'b01 and the value becomes the writeback value.
- R4: When both stages match the same source, the memory stage wins: the select is 2'b10.
- R5: When neither stage matches, the select is 2'b00 and the value is that operand's register-file input (`rf_a` or `rf_b`).
- R6: A source number of 0 never forwards, even when a stage has destination 0 and its write flag set.
- R7: A stage whose write flag is 0 never forwards, and it does not stop a matching stage whose flag is set.
- R8: The writeback value is `mwb_rdata` when `mwb_load` is 1 and `mwb_alu` when it is 0.
- R9: Operands A and B are decided independently, so in one cycle they may carry different selects.
- R10: Selects and values are registered. They change only at the rising edge after the inputs change and hold steady between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a | input | REG_W | Source register number of operand A |
| src_b | input | REG_W | Source register number of operand B |
| exm_dst | input | REG_W | Destination number in the memory-stage register |
| exm_wen | input | 1 | Memory-stage instruction writes a register |
| exm_result | input | DATA_W | ALU result held in the memory-stage register |
| mwb_dst | input | REG_W | Destination number in the writeback-stage register |
| mwb_wen | input | 1 | Writeback-stage instruction writes a register |
| mwb_load | input | 1 | Writeback-stage instruction is a load |
| mwb_alu | input | DATA_W | ALU result held in the writeback-stage register |
| mwb_rdata | input | DATA_W | Memory read data held in the writeback-stage register |
| rf_a | input | DATA_W | Register-file read value for operand A |
| rf_b | input | DATA_W | Register-file read value for operand B |
| sel_a | output | 2 | Select for operand A: 00 register file, 10 memory stage, 01 writeback |
| sel_b | output | 2 | Select for operand B, same encoding |
| opnd_a | output | DATA_W | Selected value for operand A |
| opnd_b | output | DATA_W | Selected value for operand B |

## Verification
Every select and operand value is due exactly one rising edge after the inputs that produce it. The bench drives new inputs on the falling edge, waits for the next rising edge and samples one time unit later. To confirm that the outputs are registered, it also samples just after changing the inputs, before any edge, and expects the previous results to be unchanged. The reset check applies matching inputs while reset is high and expects zeros after that same edge.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MWB = 2'b01,
    SEL_EXM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/bypass_match.sv
// One comparator per bypass path: the producer forwards to this source only
// when it writes, its destination is not register 0 and the numbers agree.
module bypass_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             wen,
  output logic             hit
);
  always_comb begin
    hit = wen && (dst != '0) && (dst == src);
  end
endmodule

// File: rtl/wb_value_pick.sv
// Value a writeback-stage producer offers: memory data for a load, else ALU.
module wb_value_pick #(
  parameter int DATA_W = 32
) (
  input  logic              is_load,
  input  logic [DATA_W-1:0] alu_val,
  input  logic [DATA_W-1:0] mem_val,
  output logic [DATA_W-1:0] wb_val
);
  always_comb begin
    wb_val = is_load ? mem_val : alu_val;
  end
endmodule

// File: rtl/operand_route.sv
// Per-operand priority pick and registered multiplexer.
module operand_route
  import bypass_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  src,
  input  logic              hit_exm,
  input  logic              hit_mwb,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] exm_val,
  input  logic [DATA_W-1:0] mwb_val,
  output logic [1:0]        sel_q,
  output logic [DATA_W-1:0] val_q
);
  fwd_sel_e          sel_d;
  logic [DATA_W-1:0] val_d;

  // The nearest producer (memory stage) takes priority.
  always_comb begin
    if (hit_exm)      sel_d = SEL_EXM;
    else if (hit_mwb) sel_d = SEL_MWB;
    else              sel_d = SEL_RF;
  end

  always_comb begin
    unique case (sel_d)
      SEL_EXM: val_d = exm_val;
      SEL_MWB: val_d = mwb_val;
      default: val_d = rf_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SEL_RF;
      val_q <= '0;
    end else begin
      sel_q <= sel_d;
      val_q <= val_d;
    end
  end

  p_exm_fwd_r2: assert property (@(posedge clk) disable iff (rst)
    hit_exm |=> (sel_q == SEL_EXM) && (val_q == $past(exm_val)));

  p_mwb_fwd_r3: assert property (@(posedge clk) disable iff (rst)
    (!hit_exm && hit_mwb) |=> (sel_q == SEL_MWB) && (val_q == $past(mwb_val)));

  p_near_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (hit_exm && hit_mwb) |=> sel_q == SEL_EXM);

  p_no_fwd_r5: assert property (@(posedge clk) disable iff (rst)
    (!hit_exm && !hit_mwb) |=> (sel_q == SEL_RF) && (val_q == $past(rf_val)));

  p_zero_src_r6: assert property (@(posedge clk) disable iff (rst)
    (src == '0) |=> sel_q == SEL_RF);
endmodule

// File: rtl/bypass_sel_unit.sv
module bypass_sel_unit
  import bypass_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  src_a,
  input  logic [REG_W-1:0]  src_b,
  input  logic [REG_W-1:0]  exm_dst,
  input  logic              exm_wen,
  input  logic [DATA_W-1:0] exm_result,
  input  logic [REG_W-1:0]  mwb_dst,
  input  logic              mwb_wen,
  input  logic              mwb_load,
  input  logic [DATA_W-1:0] mwb_alu,
  input  logic [DATA_W-1:0] mwb_rdata,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int NUM_OPS = 2;

  logic [REG_W-1:0]  src_arr [NUM_OPS];
  logic [DATA_W-1:0] rf_arr  [NUM_OPS];
  logic [1:0]        sel_arr [NUM_OPS];
  logic [DATA_W-1:0] val_arr [NUM_OPS];
  logic              hit_exm [NUM_OPS];
  logic              hit_mwb [NUM_OPS];
  logic [DATA_W-1:0] wb_val;

  assign src_arr[0] = src_a;
  assign src_arr[1] = src_b;
  assign rf_arr[0]  = rf_a;
  assign rf_arr[1]  = rf_b;

  wb_value_pick #(.DATA_W(DATA_W)) u_wb_pick (
    .is_load (mwb_load),
    .alu_val (mwb_alu),
    .mem_val (mwb_rdata),
    .wb_val  (wb_val)
  );

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    bypass_match #(.REG_W(REG_W)) u_cmp_exm (
      .src (src_arr[g]),
      .dst (exm_dst),
      .wen (exm_wen),
      .hit (hit_exm[g])
    );

    bypass_match #(.REG_W(REG_W)) u_cmp_mwb (
      .src (src_arr[g]),
      .dst (mwb_dst),
      .wen (mwb_wen),
      .hit (hit_mwb[g])
    );

    operand_route #(.REG_W(REG_W), .DATA_W(DATA_W)) u_route (
      .clk     (clk),
      .rst     (rst),
      .src     (src_arr[g]),
      .hit_exm (hit_exm[g]),
      .hit_mwb (hit_mwb[g]),
      .rf_val  (rf_arr[g]),
      .exm_val (exm_result),
      .mwb_val (wb_val),
      .sel_q   (sel_arr[g]),
      .val_q   (val_arr[g])
    );
  end

  assign sel_a  = sel_arr[0];
  assign sel_b  = sel_arr[1];
  assign opnd_a = val_arr[0];
  assign opnd_b = val_arr[1];

  // Port-level checks on the whole unit.
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (sel_a == 2'b00) && (sel_b == 2'b00) && (opnd_a == '0) && (opnd_b == '0));

  p_no_writer_r7: assert property (@(posedge clk) disable iff (rst)
    (!exm_wen && !mwb_wen) |=> (sel_a == 2'b00) && (sel_b == 2'b00));

  p_load_data_r8: assert property (@(posedge clk) disable iff (rst)
    (mwb_load && mwb_wen && mwb_dst == src_a && src_a != '0
     && !(exm_wen && exm_dst == src_a)) |=> opnd_a == $past(mwb_rdata));
endmodule

// File: tb/test_bypass_sel_unit.sv
module test_bypass_sel_unit;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;
  localparam int NVEC   = 9;
  localparam int WATCHDOG = 5000;

  localparam logic [DATA_W-1:0] RF_A  = 32'hA0A0_0001;
  localparam logic [DATA_W-1:0] RF_B  = 32'hB0B0_0002;
  localparam logic [DATA_W-1:0] EXM_V = 32'hE0E0_0003;
  localparam logic [DATA_W-1:0] ALU_V = 32'hC0C0_0004;
  localparam logic [DATA_W-1:0] MEM_V = 32'hD0D0_0005;

  // {src_a, src_b, exm_dst, exm_wen, mwb_dst, mwb_wen, mwb_load, exp_a, exp_b}
  localparam logic [26:0] VEC [NVEC] = '{
    {5'd3,  5'd4,  5'd3,  1'b1, 5'd4,  1'b1, 1'b0, 2'b10, 2'b01}, // R2 R3 R9
    {5'd5,  5'd5,  5'd5,  1'b1, 5'd5,  1'b1, 1'b0, 2'b10, 2'b10}, // R4
    {5'd6,  5'd7,  5'd8,  1'b1, 5'd9,  1'b1, 1'b0, 2'b00, 2'b00}, // R5
    {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 1'b1, 2'b00, 2'b00}, // R6
    {5'd3,  5'd3,  5'd3,  1'b0, 5'd3,  1'b0, 1'b0, 2'b00, 2'b00}, // R7
    {5'd3,  5'd3,  5'd3,  1'b0, 5'd3,  1'b1, 1'b0, 2'b01, 2'b01}, // R7
    {5'd12, 5'd2,  5'd2,  1'b1, 5'd12, 1'b1, 1'b1, 2'b01, 2'b10}, // R8 R9
    {5'd31, 5'd1,  5'd1,  1'b1, 5'd31, 1'b1, 1'b0, 2'b01, 2'b10}, // R8
    {5'd9,  5'd9,  5'd4,  1'b1, 5'd9,  1'b1, 1'b1, 2'b01, 2'b01}  // R8
  };

  logic              clk = 1'b0;
  logic              rst;
  logic [REG_W-1:0]  src_a, src_b, exm_dst, mwb_dst;
  logic              exm_wen, mwb_wen, mwb_load;
  logic [DATA_W-1:0] exm_result, mwb_alu, mwb_rdata, rf_a, rf_b;
  logic [1:0]        sel_a, sel_b;
  logic [DATA_W-1:0] opnd_a, opnd_b;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bypass_sel_unit #(.REG_W(REG_W), .DATA_W(DATA_W)) i_bypass_sel_unit (
    .clk(clk), .rst(rst), .src_a(src_a), .src_b(src_b),
    .exm_dst(exm_dst), .exm_wen(exm_wen), .exm_result(exm_result),
    .mwb_dst(mwb_dst), .mwb_wen(mwb_wen), .mwb_load(mwb_load),
    .mwb_alu(mwb_alu), .mwb_rdata(mwb_rdata), .rf_a(rf_a), .rf_b(rf_b),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  // Expected operand value from the select code (R2, R3, R5, R8).
  function automatic logic [DATA_W-1:0] exp_val(input logic [1:0] s,
                                                input logic ld,
                                                input logic [DATA_W-1:0] rf);
    case (s)
      2'b10:   return EXM_V;
      2'b01:   return ld ? MEM_V : ALU_V;
      default: return rf;
    endcase
  endfunction

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [26:0] v);
    src_a    = v[26:22];
    src_b    = v[21:17];
    exm_dst  = v[16:12];
    exm_wen  = v[11];
    mwb_dst  = v[10:6];
    mwb_wen  = v[5];
    mwb_load = v[4];
  endtask

  initial begin
    rst = 1'b1;
    rf_a = RF_A; rf_b = RF_B; exm_result = EXM_V; mwb_alu = ALU_V; mwb_rdata = MEM_V;
    apply(VEC[0]);
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset sel_a", {30'd0, sel_a}, 32'd0);
    check("R1 reset sel_b", {30'd0, sel_b}, 32'd0);
    check("R1 reset opnd_a", opnd_a, 32'd0);
    check("R1 reset opnd_b", opnd_b, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      apply(VEC[i]);
      @(posedge clk);
      #1;
      check($sformatf("R2-table sel_a vec%0d", i), {30'd0, sel_a}, {30'd0, VEC[i][3:2]});
      check($sformatf("R3-table sel_b vec%0d", i), {30'd0, sel_b}, {30'd0, VEC[i][1:0]});
      check($sformatf("R8 opnd_a vec%0d", i), opnd_a, exp_val(VEC[i][3:2], VEC[i][4], RF_A));
      check($sformatf("R9 opnd_b vec%0d", i), opnd_b, exp_val(VEC[i][1:0], VEC[i][4], RF_B));
    end

    // R10: new inputs are not visible before the next rising edge.
    @(negedge clk);
    apply(VEC[2]);
    #1;
    check("R10 sel_a holds", {30'd0, sel_a}, {30'd0, VEC[NVEC-1][3:2]});
    check("R10 opnd_a holds", opnd_a, MEM_V);
    @(posedge clk);
    #1;
    check("R10 sel_a after edge", {30'd0, sel_a}, 32'd0);
    check("R5 opnd_a rf", opnd_a, RF_A);

    // R1: reset mid-run overrides matching inputs.
    @(negedge clk);
    apply(VEC[1]);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 mid reset sel_a", {30'd0, sel_a}, 32'd0);
    check("R1 mid reset opnd_b", opnd_b, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R4 after reset sel_b", {30'd0, sel_b}, 32'd2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule